// File: doc/BRIEF.md
# ALU Status Flag Generator

A registered 32-bit arithmetic and logic unit that returns, next to each result, a six-bit status word: carry, overflow, sign, zero, a nibble-boundary auxiliary carry and an even-parity bit. An operation is issued by raising the enable for one cycle with two operands and a three-bit opcode. The result and the status word are both captured in registers and are visible on the cycle after the issue.

Add-with-carry and subtract-with-borrow take their carry input from the stored carry flag. Chained operations therefore propagate a carry or borrow from one issue to the next without any extra wiring. Compare runs a subtraction and updates only the status word, so the last computed result stays on the output. The enable is a plain control pin, not a stream handshake. The unit accepts an operation on every cycle it is raised and never applies back-pressure. With the enable low, nothing changes.

Top module: `alu_flag_core`

## Requirements
- R1: Opcode 0 (add) loads `result` with `opnd_a + opnd_b` modulo 2^32 on the cycle after issue, and sets carry (`flags[0]`) when the unsigned sum exceeds 32 bits.
- R2: Opcode 2 (subtract) loads `opnd_a - opnd_b`, and sets carry (`flags[0]`) when a borrow occurs, that is, when `opnd_b` is larger than `opnd_a` taken as unsigned numbers.
- R3: Opcode 1 (add-with-carry) adds the stored `flags[0]`, and opcode 3 (subtract-with-borrow) also subtracts it. The stored value is the one present when the operation issues, and after reset it is 0.
- R4: Overflow (`flags[1]`) is set when the signed result of an arithmetic or compare operation falls outside the 32-bit two's-complement range.
- R5: Sign (`flags[2]`) equals bit 31 of the computed value, and zero (`flags[3]`) is set when all 32 bits of that value are 0.
- R6: Auxiliary carry (`flags[4]`) is set on a carry out of bit 3 into bit 4 for additions, or on a borrow out of bit 3 for subtractions and compare.
- R7: Parity (`flags[5]`) is set when the low 8 bits of the computed value hold an even number of ones.
- R8: Opcodes 4, 5 and 6 (AND, OR, XOR) write the bitwise result and clear carry, overflow and auxiliary carry. Sign, zero and parity follow the result.
- R9: Opcode 7 (compare) computes `opnd_a - opnd_b` and updates all six flags from it, while `result` keeps its previous value.
- R10: While `issue_en` is low, `result` and `flags` hold their values whatever the other inputs do.
- R11: While `rst_n` is low, `result` and `flags` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_en | input | 1 | Issue the operation on the current inputs |
| op | input | 3 | Operation code (0 add, 1 add-with-carry, 2 sub, 3 sub-with-borrow, 4 AND, 5 OR, 6 XOR, 7 compare) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | output | 32 | Registered result |
| flags | output | 6 | Registered status: [0] carry, [1] overflow, [2] sign, [3] zero, [4] auxiliary carry, [5] parity |

## Verification
Two functions can coincide in one cycle: a carry-consuming operation reads the stored carry while the same edge overwrites it. The bench issues add-with-carry and subtract-with-borrow directly after an operation that left carry set, and again after one that left it clear. It judges both the consumed value, through the sum, and the new carry. Compare also updates the flags in the same cycle that the result register must be withheld. Two compares follow an OR with a non-zero result, and the bench checks the new flags and the unchanged result together.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_OR  = 3'd5,
    OP_XOR = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  // bit 5 down to bit 0
  typedef struct packed {
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
    logic cf;
  } status_t;

  function automatic logic op_is_bitwise(alu_op_e o);
    return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
  endfunction

  function automatic logic op_is_subtract(alu_op_e o);
    return (o == OP_SUB) || (o == OP_SBB) || (o == OP_CMP);
  endfunction

  function automatic logic op_uses_carry(alu_op_e o);
    return (o == OP_ADC) || (o == OP_SBB);
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W   = 32,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf,
  output logic         aux
);
  logic [W-1:0]   b_eff;
  logic           c_eff;
  logic [W:0]     full;
  logic [NIB:0]   low;

  // subtraction as a + ~b + ~borrow
  assign b_eff = sub ? ~b : b;
  assign c_eff = sub ? ~cin : cin;

  assign full = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
  assign low  = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};

  assign sum  = full[W-1:0];
  assign cout = full[W] ^ sub;
  assign aux  = low[NIB] ^ sub;
  assign ovf  = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_flag_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_value_flags.sv
module alu_value_flags #(
  parameter int W     = 32,
  parameter int PAR_W = 8
) (
  input  logic [W-1:0] v,
  output logic         neg,
  output logic         is_zero,
  output logic         even_par
);
  assign neg     = v[W-1];
  assign is_zero = (v == '0);

  generate
    if (PAR_W >= W) begin : g_par_full
      assign even_par = ~^v;
    end else begin : g_par_low
      assign even_par = ~^v[PAR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/alu_flag_core.sv
module alu_flag_core
  import alu_flag_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int AUX_BIT     = 4,
  parameter int PARITY_BITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_en,
  input  logic [2:0]       op,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic [5:0]       flags
);
  localparam int PW = (PARITY_BITS > WIDTH) ? WIDTH : PARITY_BITS;

  alu_op_e          op_e;
  logic             is_log, is_sub, cin;
  logic [WIDTH-1:0] sum, log_y, val;
  logic             cout, ovf, aux, neg, is_zero, even_par;
  status_t          nxt_st, st_q;
  logic [WIDTH-1:0] res_q;

  assign op_e   = alu_op_e'(op);
  assign is_log = op_is_bitwise(op_e);
  assign is_sub = op_is_subtract(op_e);
  assign cin    = op_uses_carry(op_e) & st_q.cf;

  alu_addsub #(.W(WIDTH), .NIB(AUX_BIT)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(is_sub), .cin(cin),
    .sum(sum), .cout(cout), .ovf(ovf), .aux(aux)
  );

  alu_bitwise #(.W(WIDTH)) u_bitwise (
    .op(op_e), .a(opnd_a), .b(opnd_b), .y(log_y)
  );

  assign val = is_log ? log_y : sum;

  alu_value_flags #(.W(WIDTH), .PAR_W(PW)) u_vflags (
    .v(val), .neg(neg), .is_zero(is_zero), .even_par(even_par)
  );

  always_comb begin
    nxt_st.cf = is_log ? 1'b0 : cout;
    nxt_st.of = is_log ? 1'b0 : ovf;
    nxt_st.af = is_log ? 1'b0 : aux;
    nxt_st.sf = neg;
    nxt_st.zf = is_zero;
    nxt_st.pf = even_par;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
      st_q  <= '0;
    end else if (issue_en) begin
      st_q <= nxt_st;
      if (op_e != OP_CMP) res_q <= val;
    end
  end

  assign result = res_q;
  assign flags  = st_q;

  // R10: idle cycles leave both registers untouched
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_en |=> ($stable(result) && $stable(flags)));

  // R9: compare never writes the result register
  p_cmp_keeps_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && op == 3'd7) |=> $stable(result));

  // R8: bitwise operations leave carry, overflow and aux clear
  p_bitwise_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && (op == 3'd4 || op == 3'd5 || op == 3'd6))
      |=> (flags[0] == 1'b0 && flags[1] == 1'b0 && flags[4] == 1'b0));

  // R5: sign and zero agree with the written result
  p_sign_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && op != 3'd7)
      |=> (flags[2] == result[WIDTH-1] && flags[3] == (result == '0)));

  // R7: parity agrees with the low bits of the written result
  p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && op != 3'd7) |=> (flags[5] == ~^result[PW-1:0]));

  // R4: bitwise issue can never leave overflow set, arithmetic add of two
  // same-sign operands with a sign flip must
  p_add_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_en && op == 3'd0 && opnd_a[WIDTH-1] == opnd_b[WIDTH-1])
      |=> (flags[1] == (result[WIDTH-1] != $past(opnd_a[WIDTH-1]))));

endmodule

// File: tb/tb_alu_flag_core.sv
`timescale 1ns/1ps
module tb_alu_flag_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_en;
  logic [2:0]  op;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] result;
  logic [5:0]  flags;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  alu_flag_core dut (
    .clk(clk), .rst_n(rst_n), .issue_en(issue_en), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result), .flags(flags)
  );

  // {op, a, b, expected result, expected flags pf,af,zf,sf,of,cf}
  localparam int NV = 15;
  localparam logic [104:0] VEC [NV] = '{
    {3'd0, 32'h00000001, 32'h00000001, 32'h00000002, 6'h00}, // R1
    {3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 6'h39}, // R1 R6 carry out
    {3'd1, 32'h00000000, 32'h00000000, 32'h00000001, 6'h00}, // R3 stored carry 1
    {3'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 6'h36}, // R4 signed overflow
    {3'd2, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 6'h15}, // R2 borrow
    {3'd1 + 3'd2, 32'h0000000A, 32'h00000003, 32'h00000006, 6'h20}, // R3 borrow in
    {3'd2, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 6'h32}, // R4 sub overflow
    {3'd4, 32'hF0F0F0F0, 32'h0FF00FF0, 32'h00F000F0, 6'h20}, // R8 clears
    {3'd3, 32'h00000020, 32'h00000010, 32'h00000010, 6'h00}, // R3 borrow 0
    {3'd6, 32'h12345678, 32'h12345678, 32'h00000000, 6'h28}, // R8 R5 zero
    {3'd5, 32'h80000000, 32'h00000003, 32'h80000003, 6'h24}, // R8 R7
    {3'd7, 32'h00000003, 32'h00000005, 32'h80000003, 6'h15}, // R9
    {3'd7, 32'h00000009, 32'h00000009, 32'h80000003, 6'h28}, // R9
    {3'd1, 32'h0000000F, 32'h00000001, 32'h00000010, 6'h10}, // R6 nibble carry
    {3'd0, 32'h80000000, 32'h80000000, 32'h00000000, 6'h2B}  // R4 neg+neg
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op = o; opnd_a = a; opnd_b = b; issue_en = 1'b1;
    @(negedge clk);
    issue_en = 1'b0;
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1 add";
      3'd1, 3'd3: return "R3 carry-in";
      3'd2: return "R2 sub";
      3'd7: return "R9 compare";
      default: return "R8 bitwise";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; issue_en = 1'b0; op = 3'd0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset result", result, 32'h0);
    check("R11 reset flags", {26'h0, flags}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][104:102], VEC[i][101:70], VEC[i][69:38]);
      check(tag_of(VEC[i][104:102]), result, VEC[i][37:6]);
      check("R4/R5/R6/R7 flags", {26'h0, flags}, {26'h0, VEC[i][5:0]});
    end

    // R10: inputs move while enable stays low
    @(negedge clk);
    op = 3'd2; opnd_a = 32'h11111111; opnd_b = 32'h22222222;
    repeat (3) @(negedge clk);
    op = 3'd5;
    @(negedge clk);
    check("R10 idle result", result, 32'h0);
    check("R10 idle flags", {26'h0, flags}, 32'h2B);

    // R11: reset mid-run clears stored carry too
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 mid reset result", result, 32'h0);
    check("R11 mid reset flags", {26'h0, flags}, 32'h0);
    rst_n = 1'b1;
    issue(3'd1, 32'h2, 32'h3);
    check("R3 carry after reset", result, 32'h5);
    check("R7 parity after reset", {26'h0, flags}, 32'h20);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule